// File: doc/BRIEF.md
# Packet Transmit Sequencer with Acknowledgment Wait

This block runs the transmit side of a node on a shared serial bus. A requester hands it a destination address and a payload length. The payload itself already sits in an external transmit buffer. The block then works through a fixed sequence:

1. It arbitrates for the line by waiting for a quiet period that depends on the node address.
2. It streams two sync bytes, a three-byte header and the payload bytes to the line serializer.
3. It appends a 32-bit CRC.
4. It waits a bounded time for the reply packet and classifies it.

The outcome is reported as a one-cycle result pulse: ACK, NACK or timeout.

The byte stream towards the serializer is a valid/ready interface. A byte is transferred on any clock edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the sequencer holds `tx_valid` high and `tx_data` unchanged, however long the stall lasts. The buffer is read through a combinational port: the block drives a byte offset and expects the byte back in the same cycle. Carrier detect, the request, the reply indication and the result are plain level or pulse signals.

Top module: `pkt_tx_sequencer`

## Requirements
- R1: `req_valid` sampled while the block is idle is accepted, and `busy` is high in the following cycle. Requests that arrive while `busy` is high have no effect on the frame being sent or on the result.
- R2: With `carrier` low, the first byte is offered (`tx_valid` high) exactly QUIET_CYC + SLOT_CYC × `node_id` cycles after the accepting edge (16 + 4 × `node_id` by default). No byte is offered before that.
- R3: A cycle with `carrier` high during arbitration restarts the quiet count. The first byte then appears a full QUIET_CYC + SLOT_CYC × `node_id` quiet cycles after the last busy cycle, and never in the cycle right after `carrier` was high.
- R4: The frame bytes go out in this order:
  - two sync bytes of value 0x96;
  - the destination address, zero-extended to 8 bits;
  - `node_id`, zero-extended to 8 bits;
  - the length;
  - payload buffer offsets 0 up to length−1;
  - the four CRC bytes.
- R5: The CRC runs over the destination, source, length and payload bytes. It uses the bit-reflected polynomial 0xEDB88320 with an initial value of all ones. The register value is inverted and sent least significant byte first.
- R6: The offered byte advances only on a handshake. While `tx_valid` is high and `tx_ready` is low, `tx_data` is held stable in the next cycle.
- R7: After the last CRC byte, `ack_valid` sampled with `ack_nack` low ends the wait with `done` in the next cycle and `result` 2'b01 (ACK). With `ack_nack` high, the result is 2'b10 (NACK). A reply has priority over a timeout that falls in the same cycle.
- R8: If no reply is sampled within ACK_WAIT cycles (256 by default), `done` rises exactly ACK_WAIT cycles after the last byte handshake, with `result` 2'b11 (timeout).
- R9: `done` is a single-cycle pulse. `busy` is low in that cycle, and the block is idle again. `ack_valid` outside the wait phase causes no result.
- R10: During and after reset, `busy`, `tx_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | ADDR_W | Own node address; sets the arbitration delay and the header source byte |
| req_valid | input | 1 | Send request, taken while idle |
| req_dst | input | ADDR_W | Destination address for the request |
| req_len | input | LEN_W | Payload length in bytes |
| busy | output | 1 | High from acceptance until the result pulse |
| carrier | input | 1 | Another node is using the line |
| buf_rd_addr | output | LEN_W | Payload byte offset into the transmit buffer |
| buf_rd_data | input | 8 | Buffer byte at `buf_rd_addr`, same cycle |
| tx_valid | output | 1 | A byte is offered to the serializer |
| tx_ready | input | 1 | Serializer accepts the offered byte |
| tx_data | output | 8 | Offered byte |
| ack_valid | input | 1 | Reply packet indication from the receive side |
| ack_nack | input | 1 | Reply kind: 0 ACK, 1 NACK |
| done | output | 1 | One-cycle result pulse |
| result | output | 2 | 01 ACK, 10 NACK, 11 timeout; valid with `done` |

## Verification
The bench builds the block with its default parameters: a 4-bit address, an 8-bit length, a 16-cycle quiet period, 4 cycles per address step and a 256-cycle reply window. The full timeout path therefore completes within a few hundred cycles and can be measured to the exact cycle. The bench drives `node_id` values of 0, 3, 5 and 15, which spans the shortest and longest arbitration delays. It also includes a zero-length frame, so the header runs straight into the CRC. Serializer back-pressure is pseudo-random throughout, so stalls land on sync, header, payload and CRC bytes alike.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARB,
    ST_SEND,
    ST_WAIT
  } tx_state_e;

  localparam logic [1:0] RES_ACK  = 2'b01;
  localparam logic [1:0] RES_NACK = 2'b10;
  localparam logic [1:0] RES_TMO  = 2'b11;

  localparam int SYNC_COUNT = 2;
  localparam int HDR_COUNT  = 3;
  localparam int CRC_COUNT  = 4;

  localparam logic [31:0] CRC_POLY_REV = 32'hEDB88320;

  // One byte of reflected CRC-32, least significant bit first.
  function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REV) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/txs_arbiter.sv
module txs_arbiter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             carrier,
  input  logic [CNT_W-1:0] need,
  output logic             granted
);
  logic [CNT_W-1:0] quiet_q;

  assign granted = active && !carrier && (quiet_q == need - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !active || carrier) begin
      quiet_q <= '0;
    end else if (!granted) begin
      quiet_q <= quiet_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/txs_ack_timer.sv
module txs_ack_timer #(
  parameter int ACK_WAIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic expired
);
  localparam int TW = $clog2(ACK_WAIT + 1);

  logic [TW-1:0] cnt_q;

  assign expired = active && (cnt_q == TW'(ACK_WAIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      cnt_q <= '0;
    end else if (!expired) begin
      cnt_q <= cnt_q + TW'(1);
    end
  end
endmodule

// File: rtl/txs_crc32.sv
module txs_crc32 import pkt_tx_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        update,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      crc_q <= '1;
    end else if (update) begin
      crc_q <= crc_step(crc_q, din);
    end
  end
endmodule

// File: rtl/pkt_tx_sequencer.sv
module pkt_tx_sequencer import pkt_tx_pkg::*; #(
  parameter int          ADDR_W    = 4,
  parameter int          LEN_W     = 8,
  parameter int          QUIET_CYC = 16,
  parameter int          SLOT_CYC  = 4,
  parameter int          ACK_WAIT  = 256,
  parameter logic [7:0]  SYNC_BYTE = 8'h96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] node_id,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_dst,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  input  logic              carrier,
  output logic [LEN_W-1:0]  buf_rd_addr,
  input  logic [7:0]        buf_rd_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              ack_valid,
  input  logic              ack_nack,
  output logic              done,
  output logic [1:0]        result
);
  localparam int NEED_MAX = QUIET_CYC + SLOT_CYC * ((1 << ADDR_W) - 1);
  localparam int CNT_W    = $clog2(NEED_MAX + 1);
  localparam int IDX_W    = LEN_W + 2;
  localparam int PAY_OFS  = SYNC_COUNT + HDR_COUNT;

  tx_state_e         state_q;
  logic [ADDR_W-1:0] dst_q;
  logic [LEN_W-1:0]  len_q;
  logic [IDX_W-1:0]  idx_q;
  logic              done_q;
  logic [1:0]        result_q;

  logic              accept, hs, granted, expired, crc_upd;
  logic [CNT_W-1:0]  need;
  logic [IDX_W-1:0]  pay_end, last_idx;
  logic [1:0]        crc_sel;
  logic [31:0]       crc_q, crc_out;

  assign accept   = req_valid && (state_q == ST_IDLE);
  assign hs       = (state_q == ST_SEND) && tx_ready;
  assign need     = CNT_W'(QUIET_CYC) + CNT_W'(SLOT_CYC) * CNT_W'(node_id);
  assign pay_end  = IDX_W'(PAY_OFS) + IDX_W'(len_q);
  assign last_idx = pay_end + IDX_W'(CRC_COUNT - 1);
  assign crc_sel  = 2'(idx_q - pay_end);
  assign crc_out  = ~crc_q;
  assign crc_upd  = hs && (idx_q >= IDX_W'(SYNC_COUNT)) && (idx_q < pay_end);

  assign busy        = (state_q != ST_IDLE);
  assign tx_valid    = (state_q == ST_SEND);
  assign buf_rd_addr = LEN_W'(idx_q - IDX_W'(PAY_OFS));
  assign done        = done_q;
  assign result      = result_q;

  txs_arbiter #(.CNT_W(CNT_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (state_q == ST_ARB),
    .carrier (carrier),
    .need    (need),
    .granted (granted)
  );

  txs_ack_timer #(.ACK_WAIT(ACK_WAIT)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (state_q == ST_WAIT),
    .expired (expired)
  );

  txs_crc32 u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .update (crc_upd),
    .din    (tx_data),
    .crc_q  (crc_q)
  );

  // Frame byte selection: sync, header, payload, inverted CRC (LS byte first)
  always_comb begin
    if (idx_q < IDX_W'(SYNC_COUNT)) begin
      tx_data = SYNC_BYTE;
    end else if (idx_q == IDX_W'(SYNC_COUNT)) begin
      tx_data = 8'(dst_q);
    end else if (idx_q == IDX_W'(SYNC_COUNT + 1)) begin
      tx_data = 8'(node_id);
    end else if (idx_q == IDX_W'(SYNC_COUNT + 2)) begin
      tx_data = 8'(len_q);
    end else if (idx_q < pay_end) begin
      tx_data = buf_rd_data;
    end else begin
      case (crc_sel)
        2'd0:    tx_data = crc_out[7:0];
        2'd1:    tx_data = crc_out[15:8];
        2'd2:    tx_data = crc_out[23:16];
        default: tx_data = crc_out[31:24];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      dst_q    <= '0;
      len_q    <= '0;
      idx_q    <= '0;
      done_q   <= 1'b0;
      result_q <= 2'b00;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            dst_q   <= req_dst;
            len_q   <= req_len;
            idx_q   <= '0;
            state_q <= ST_ARB;
          end
        end
        ST_ARB: begin
          if (granted) state_q <= ST_SEND;
        end
        ST_SEND: begin
          if (hs) begin
            if (idx_q == last_idx) state_q <= ST_WAIT;
            else                   idx_q   <= idx_q + IDX_W'(1);
          end
        end
        ST_WAIT: begin
          if (ack_valid) begin
            done_q   <= 1'b1;
            result_q <= ack_nack ? RES_NACK : RES_ACK;
            state_q  <= ST_IDLE;
          end else if (expired) begin
            done_q   <= 1'b1;
            result_q <= RES_TMO;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txs_checker.sv
module txs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       busy,
  input logic       carrier,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       done,
  input logic [1:0] result
);
  // R1
  accept_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R1
  busy_ends_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R2
  offer_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy);

  // R3
  no_start_after_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> !$past(carrier));

  // R6
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R9
  done_idle_coded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && (result != 2'b00)));

  // R9
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!tx_valid && !done));
endmodule

bind pkt_tx_sequencer txs_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .carrier   (carrier),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .done      (done),
  .result    (result)
);

// File: tb/pkt_tx_sequencer_bench.sv
module pkt_tx_sequencer_bench;
  localparam int ADDR_W = 4;
  localparam int LEN_W  = 8;
  localparam int QUIET  = 16;
  localparam int SLOT   = 4;
  localparam int WAITC  = 256;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] node_id = '0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_dst = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic              busy;
  logic              carrier = 1'b0;
  logic [LEN_W-1:0]  buf_rd_addr;
  logic [7:0]        buf_rd_data;
  logic              tx_valid;
  logic              tx_ready = 1'b0;
  logic [7:0]        tx_data;
  logic              ack_valid = 1'b0;
  logic              ack_nack = 1'b0;
  logic              done;
  logic [1:0]        result;

  logic [7:0] mem [256];
  assign buf_rd_data = mem[buf_rd_addr];

  pkt_tx_sequencer u_pkt_tx_sequencer (
    .clk, .rst_n, .node_id, .req_valid, .req_dst, .req_len, .busy, .carrier,
    .buf_rd_addr, .buf_rd_data, .tx_valid, .tx_ready, .tx_data,
    .ack_valid, .ack_nack, .done, .result
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int last_hs_cyc = 0;
  bit finished = 0;
  logic [7:0] exp_q [$];

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Pseudo-random back-pressure, changed away from the clock edge
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready = lfsr[0] | lfsr[1];
  end

  // Monitor: scoreboard compare and stall stability
  bit         prev_stall = 0;
  logic [7:0] prev_data = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(tx_valid && tx_data == prev_data, "R6 held byte", int'(tx_data), int'(prev_data));
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R1/R4 unexpected byte", int'(tx_data), -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(tx_data == e, "R4/R5 frame byte", int'(tx_data), int'(e));
        end
        last_hs_cyc = cyc + 1;
      end
    end
  end

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  // Driver side: expected frame into the scoreboard queue
  task automatic push_frame(input int node, input int dst, input int len);
    logic [31:0] c;
    logic [7:0]  hdr [3];
    c = 32'hFFFFFFFF;
    exp_q.push_back(8'h96);
    exp_q.push_back(8'h96);
    hdr[0] = 8'(dst);
    hdr[1] = 8'(node);
    hdr[2] = 8'(len);
    for (int i = 0; i < 3; i++) begin
      exp_q.push_back(hdr[i]);
      c = ref_crc(c, hdr[i]);
    end
    for (int i = 0; i < len; i++) begin
      exp_q.push_back(mem[i]);
      c = ref_crc(c, mem[i]);
    end
    c = ~c;
    for (int i = 0; i < 4; i++) exp_q.push_back(c[8*i +: 8]);
  endtask

  // reply: 0 ACK, 1 NACK, 2 none (timeout)
  task automatic run_packet(input int node, input int dst, input int len, input int hold,
                            input int reply, input int ack_delay, input bit stray);
    int n;
    node_id = ADDR_W'(node);
    push_frame(node, dst, len);
    @(negedge clk);
    req_valid = 1'b1;
    req_dst   = ADDR_W'(dst);
    req_len   = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R1 busy after accept", int'(busy), 1);
    n = 0;
    while (!tx_valid && n < 2000) begin
      carrier   = (n < hold);
      ack_valid = stray && (n == 2);
      @(negedge clk);
      n++;
    end
    carrier   = 1'b0;
    ack_valid = 1'b0;
    if (hold > 0) check(n == hold + QUIET + SLOT * node, "R3 restart delay", n, hold + QUIET + SLOT * node);
    else          check(n == QUIET + SLOT * node, "R2 arbitration delay", n, QUIET + SLOT * node);
    if (stray) begin
      req_valid = 1'b1;
      req_dst   = ~ADDR_W'(dst);
      req_len   = 8'd3;
      @(negedge clk);
      req_valid = 1'b0;
      check(busy == 1'b1, "R1 ignored while busy", int'(busy), 1);
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
    check(busy == 1'b1 && done == 1'b0, "R7 waiting for reply", int'(done), 0);
    if (reply < 2) begin
      repeat (ack_delay) begin
        @(negedge clk);
        check(done == 1'b0, "R7 no early result", int'(done), 0);
      end
      ack_valid = 1'b1;
      ack_nack  = (reply == 1);
      @(negedge clk);
      ack_valid = 1'b0;
      ack_nack  = 1'b0;
      check(done == 1'b1 && result == ((reply == 1) ? 2'b10 : 2'b01), "R7 reply result",
            int'({done, result}), (reply == 1) ? 6 : 5);
    end else begin
      n = 0;
      while (!done && n < 1000) begin
        @(negedge clk);
        n++;
      end
      check(done == 1'b1 && result == 2'b11, "R8 timeout result", int'({done, result}), 7);
      check(cyc - last_hs_cyc == WAITC, "R8 timeout cycles", cyc - last_hs_cyc, WAITC);
    end
    check(busy == 1'b0, "R9 idle with done", int'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, "R9 single pulse", int'(done), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(busy == 1'b0 && tx_valid == 1'b0 && done == 1'b0, "R10 reset outputs",
          int'({busy, tx_valid, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reply outside the wait phase is ignored
    ack_valid = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R9 stray reply while idle", int'({done, busy}), 0);

    run_packet(0, 5, 4, 0, 0, 5, 0);     // R2 R4 R5 R7 ACK
    run_packet(3, 9, 1, 10, 1, 2, 0);    // R3 NACK
    run_packet(15, 2, 0, 0, 2, 0, 0);    // R2 longest delay, R8 timeout, empty payload
    run_packet(5, 12, 20, 0, 0, 0, 1);   // R1 ignored request, R9 stray reply
    run_packet(1, 7, 2, 0, 2, 0, 0);     // R8 again

    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule